// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge lets a host that only has a narrow four-location, byte-wide window reach a 16-bit internal byte address space. The host programs a pointer by writing its upper and lower bytes into two window locations, then moves data through a fourth location. Each enabled access to that data location becomes one access to the internal synchronous memory at the pointer. A control location holds three flags: interface enable, pointer auto-advance, and a byte-order flag that the bridge only stores and drives out.

With auto-advance set, the host can stream a block of bytes in or out with back-to-back data accesses and no pointer rewrites. Because the pointer bytes can be read back, interrupt code can save the pointer, use the window, and restore the pointer before returning.

Top module: `xwb_bridge`

## Requirements
- R1: After reset the control location reads 0x00, both pointer bytes read 0x00, `le_mode` is 0 and `host_rvalid` is 0.
- R2: The window offset selects the location: 0 is control, 1 is the pointer upper byte, 2 is the pointer lower byte, 3 is the data port. A read of any location returns its value on `host_rdata` with `host_rvalid` high in the cycle after the request. Control reads return only bits 7, 1 and 0 as written; the other bits read 0.
- R3: While control bit 7 (enable) is 0, a data port access asserts neither `mem_en` nor `mem_we`, leaves the pointer unchanged, and a data port read returns 0x00.
- R4: `le_mode` equals control bit 1 (1 = little endian, 0 = big endian) from the cycle after the control write.
- R5: An enabled data port write asserts `mem_en` and `mem_we` in the request cycle, with `mem_addr` equal to {upper byte, lower byte} and `mem_wdata` equal to the host byte.
- R6: An enabled data port read asserts `mem_en` with `mem_we` low at the pointer, and returns the memory byte one cycle later.
- R7: With control bit 0 (auto-advance) set, the pointer is one higher after each enabled data access, as seen through the pointer byte locations. With bit 0 clear, it does not change.
- R8: Advancing from 0xFFFF gives 0x0000.
- R9: Writing the pointer bytes between data accesses moves the stream to the new address. Writing back saved pointer bytes restores the earlier position.
- R10: `host_rvalid` is high for exactly one cycle after each read request and is never high after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 2 | Window offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read return byte |
| host_rvalid | output | 1 | Read return valid |
| le_mode | output | 1 | Stored byte-order flag |
| mem_en | output | 1 | Internal memory access enable |
| mem_we | output | 1 | Internal memory write enable |
| mem_addr | output | 16 | Internal memory byte address |
| mem_wdata | output | 8 | Internal memory write byte |
| mem_rdata | input | 8 | Internal memory read byte, one cycle after `mem_en` |

## Verification
The assertions check four things on every cycle:
- a memory write is never issued without a memory access;
- no memory access occurs while the interface is disabled;
- the pointer steps by exactly one after each access when auto-advance is on, and holds when it is off;
- a read return follows every read request and nothing else.

Only the bench scenarios can show the data-level behaviour: the correct bytes arriving at the correct addresses during a stream, redirection after the pointer is rewritten, the wrap from 0xFFFF, save and restore of the pointer, and the masked read-back of the control location.

// File: rtl/xwb_pkg.sv
package xwb_pkg;
  localparam int OPT_EN_BIT  = 7;
  localparam int OPT_LE_BIT  = 1;
  localparam int OPT_INC_BIT = 0;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_AHI  = 2'd1,
    OFS_ALO  = 2'd2,
    OFS_DATA = 2'd3
  } win_ofs_e;
endpackage

// File: rtl/xwb_regs.sv
module xwb_regs #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic          bump,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [AW-1:0] ptr_q
);
  import xwb_pkg::*;

  localparam logic [DW-1:0] CTRL_MASK =
    DW'((1 << OPT_EN_BIT) | (1 << OPT_LE_BIT) | (1 << OPT_INC_BIT));

  logic [DW-1:0] ctrl_d;
  logic [AW-1:0] ptr_d;
  logic          ctrl_ce, ptr_ce;

  always_comb begin
    ctrl_d  = ctrl_q;
    ptr_d   = ptr_q;
    ctrl_ce = wr_ctrl;
    ptr_ce  = wr_hi | wr_lo | bump;
    if (wr_ctrl) ctrl_d = wdata & CTRL_MASK;
    if (wr_hi)   ptr_d[AW-1:DW] = wdata;
    if (wr_lo)   ptr_d[DW-1:0]  = wdata;
    if (bump)    ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (ptr_ce)  ptr_q  <= ptr_d;
    end
  end
endmodule

// File: rtl/xwb_rdpath.sv
module xwb_rdpath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          rd_is_mem,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid
);
  logic          vld_q, vld_d;
  logic          from_mem_q, from_mem_d;
  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    vld_d      = rd_req;
    from_mem_d = from_mem_q;
    hold_d     = hold_q;
    if (rd_req) begin
      from_mem_d = rd_is_mem;
      hold_d     = reg_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      from_mem_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      vld_q <= vld_d;
      if (rd_req) begin
        from_mem_q <= from_mem_d;
        hold_q     <= hold_d;
      end
    end
  end

  assign host_rvalid = vld_q;
  assign host_rdata  = from_mem_q ? mem_rdata : hold_q;
endmodule

// File: rtl/xwb_bridge.sv
module xwb_bridge #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [1:0]    host_ofs,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          le_mode,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import xwb_pkg::*;

  logic [1:0]    rsync_q;
  logic          rst_q_n;
  logic [DW-1:0] ctrl_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] reg_val;
  logic          data_hit, data_go;
  win_ofs_e      ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  assign ofs      = win_ofs_e'(host_ofs);
  assign data_hit = host_sel && (ofs == OFS_DATA);
  assign data_go  = data_hit && ctrl_q[OPT_EN_BIT];

  always_comb begin
    case (ofs)
      OFS_CTRL: reg_val = ctrl_q;
      OFS_AHI:  reg_val = ptr_q[AW-1:DW];
      OFS_ALO:  reg_val = ptr_q[DW-1:0];
      default:  reg_val = '0;
    endcase
  end

  xwb_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_ctrl (host_sel && host_wr && (ofs == OFS_CTRL)),
    .wr_hi   (host_sel && host_wr && (ofs == OFS_AHI)),
    .wr_lo   (host_sel && host_wr && (ofs == OFS_ALO)),
    .bump    (data_go && ctrl_q[OPT_INC_BIT]),
    .wdata   (host_wdata),
    .ctrl_q  (ctrl_q),
    .ptr_q   (ptr_q)
  );

  xwb_rdpath #(.DW(DW)) u_rd (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .rd_req      (host_sel && !host_wr),
    .rd_is_mem   (data_go),
    .reg_val     (reg_val),
    .mem_rdata   (mem_rdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  assign le_mode   = ctrl_q[OPT_LE_BIT];
  assign mem_en    = data_go;
  assign mem_we    = data_go && host_wr;
  assign mem_addr  = ptr_q;
  assign mem_wdata = host_wdata;
endmodule

// File: rtl/xwb_bridge_chk.sv
module xwb_bridge_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic          host_wr,
  input logic          host_rvalid,
  input logic          mem_en,
  input logic          mem_we,
  input logic          en_bit,
  input logic          inc_bit,
  input logic [AW-1:0] ptr
);
  // R5: a memory write only happens as part of a memory access
  a_r5_we_within_en: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R3: a disabled interface issues no memory access
  a_r3_no_mem_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_bit |-> !mem_en);

  // R7: the pointer steps by exactly one when auto-advance is on
  a_r7_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && inc_bit) |=> (ptr == $past(ptr) + AW'(1)));

  // R7: the pointer holds when auto-advance is off
  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !inc_bit) |=> $stable(ptr));

  // R10: every read request is followed by one return
  a_r10_ret_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr) |=> host_rvalid);

  // R10: no return without a read request
  a_r10_no_spurious_ret: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_sel && !host_wr) |=> !host_rvalid);
endmodule

bind xwb_bridge xwb_bridge_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .host_sel    (host_sel),
  .host_wr     (host_wr),
  .host_rvalid (host_rvalid),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .en_bit      (ctrl_q[xwb_pkg::OPT_EN_BIT]),
  .inc_bit     (ctrl_q[xwb_pkg::OPT_INC_BIT]),
  .ptr         (ptr_q)
);

// File: tb/sim_xwb_bridge.sv
`timescale 1ns/1ps
module sim_xwb_bridge;
  localparam int RAM_AW = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_ofs = 2'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        host_rvalid, le_mode, mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic        s_en, s_we;
  logic [15:0] s_addr;
  logic [7:0]  s_wdata;
  logic        s_rvalid_after_wr;

  logic [7:0] ram [0:(1<<RAM_AW)-1];
  logic [7:0] ram_q;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_en && mem_we) ram[mem_addr[RAM_AW-1:0]] <= mem_wdata;
    if (mem_en && !mem_we) ram_q <= ram[mem_addr[RAM_AW-1:0]];
  end
  assign mem_rdata = ram_q;

  xwb_bridge u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .le_mode(le_mode), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] ofs, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_ofs = ofs; host_wdata = d;
    #1;
    s_en = mem_en; s_we = mem_we; s_addr = mem_addr; s_wdata = mem_wdata;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    #1;
    s_rvalid_after_wr = host_rvalid;
  endtask

  task automatic hread(input logic [1:0] ofs, output logic [7:0] d, output logic v);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_ofs = ofs;
    #1;
    s_en = mem_en; s_we = mem_we; s_addr = mem_addr;
    @(negedge clk);
    host_sel = 1'b0;
    #1;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    hwrite(2'd1, a[15:8]);
    hwrite(2'd2, a[7:0]);
  endtask

  task automatic get_ptr(output logic [15:0] a);
    logic [7:0] h, l; logic v;
    hread(2'd1, h, v);
    hread(2'd2, l, v);
    a = {h, l};
  endtask

  task automatic t_reset;
    logic [7:0] d; logic v;
    chk("R1 le_mode", le_mode, 0);
    chk("R1 rvalid", host_rvalid, 0);
    hread(2'd0, d, v); chk("R1 ctrl", d, 8'h00);
    hread(2'd1, d, v); chk("R1 ptr hi", d, 8'h00);
    hread(2'd2, d, v); chk("R1 ptr lo", d, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d; logic v; logic [15:0] a;
    hwrite(2'd0, 8'hFF);
    chk("R10 no rvalid after write", s_rvalid_after_wr, 0);
    chk("R4 le_mode set", le_mode, 1);
    hread(2'd0, d, v);
    chk("R2 ctrl mask", d, 8'h83);
    chk("R2 rvalid", v, 1);
    hwrite(2'd0, 8'h80);
    chk("R4 le_mode clear", le_mode, 0);
    set_ptr(16'h1234);
    get_ptr(a);
    chk("R2 ptr readback", a, 16'h1234);
    @(negedge clk); #1;
    chk("R10 idle no rvalid", host_rvalid, 0);
  endtask

  task automatic t_disabled;
    logic [7:0] d; logic v; logic [15:0] a;
    hwrite(2'd0, 8'h01);
    set_ptr(16'h0010);
    ram[9'h010] = 8'h3C;
    hwrite(2'd3, 8'h5A);
    chk("R3 no mem_en on write", s_en, 0);
    chk("R3 no mem_we", s_we, 0);
    chk("R3 ram untouched", ram[9'h010], 8'h3C);
    hread(2'd3, d, v);
    chk("R3 no mem_en on read", s_en, 0);
    chk("R3 read zero", d, 8'h00);
    chk("R10 rvalid disabled read", v, 1);
    get_ptr(a);
    chk("R3 ptr unchanged", a, 16'h0010);
  endtask

  task automatic t_single;
    logic [7:0] d; logic v; logic [15:0] a;
    hwrite(2'd0, 8'h80);
    set_ptr(16'h0020);
    hwrite(2'd3, 8'hC3);
    chk("R5 mem_en", s_en, 1);
    chk("R5 mem_we", s_we, 1);
    chk("R5 mem_addr", s_addr, 16'h0020);
    chk("R5 mem_wdata", s_wdata, 8'hC3);
    chk("R5 ram", ram[9'h020], 8'hC3);
    get_ptr(a);
    chk("R7 no advance when off", a, 16'h0020);
    hread(2'd3, d, v);
    chk("R6 mem read strobe", {s_en, s_we}, 2'b10);
    chk("R6 read data", d, 8'hC3);
    chk("R6 rvalid", v, 1);
  endtask

  task automatic t_stream;
    logic [7:0] d; logic v; logic [15:0] a;
    hwrite(2'd0, 8'h81);
    set_ptr(16'h0100);
    for (int i = 0; i < 16; i++) hwrite(2'd3, 8'hA0 + 8'(i));
    get_ptr(a);
    chk("R7 ptr after 16 writes", a, 16'h0110);
    set_ptr(16'h0120);
    for (int i = 0; i < 4; i++) hwrite(2'd3, 8'h50 + 8'(i));
    chk("R9 redirected addr", s_addr, 16'h0123);
    for (int i = 0; i < 16; i++) chk("R7 stream ram", ram[9'h100 + 9'(i)], 8'hA0 + 8'(i));
    chk("R9 redirect ram", ram[9'h121], 8'h51);
    set_ptr(16'h0100);
    for (int i = 0; i < 16; i++) begin
      hread(2'd3, d, v);
      chk("R6 stream read", d, 8'hA0 + 8'(i));
    end
    get_ptr(a);
    chk("R7 ptr after 16 reads", a, 16'h0110);
  endtask

  task automatic t_wrap;
    logic [7:0] d; logic v; logic [15:0] a;
    set_ptr(16'hFFFF);
    hwrite(2'd3, 8'h77);
    chk("R8 write addr", s_addr, 16'hFFFF);
    get_ptr(a);
    chk("R8 wrap after write", a, 16'h0000);
    set_ptr(16'hFFFF);
    hread(2'd3, d, v);
    chk("R8 read at top", d, 8'h77);
    get_ptr(a);
    chk("R8 wrap after read", a, 16'h0000);
  endtask

  task automatic t_save_restore;
    logic [7:0] h, l, d; logic v; logic [15:0] a;
    set_ptr(16'h0140);
    hread(2'd1, h, v);
    hread(2'd2, l, v);
    set_ptr(16'h0180);
    hwrite(2'd3, 8'h11);
    hwrite(2'd1, h);
    hwrite(2'd2, l);
    get_ptr(a);
    chk("R9 restored ptr", a, 16'h0140);
    hwrite(2'd3, 8'h22);
    chk("R9 restored write addr", s_addr, 16'h0140);
    set_ptr(16'h0180);
    hread(2'd3, d, v);
    chk("R9 other stream intact", d, 8'h11);
  endtask

  initial begin
    for (int i = 0; i < (1 << RAM_AW); i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_single();
    t_stream();
    t_wrap();
    t_save_restore();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule